// File: doc/BRIEF.md
# Edge-Tracking Oversampled UART Receiver

This block receives asynchronous serial frames when the sender's bit rate does not exactly match the local one. It samples the line on a tick that runs at four times the nominal bit rate. It also acts like a small digital phase-locked loop: each time the line changes state inside a frame, it restarts its bit timing, so the sample point moves back toward the middle of the next bit. Timing error therefore builds up only across runs of bits with no transition, and not across the whole frame.

Each frame has a low start bit, from one to eight data bits sent least-significant first, an optional parity bit and a stop bit. Configuration inputs select the data width, whether parity is used, even or odd parity, and whether the stop bit is checked. The receiver latches these settings when a frame starts. It returns each frame as a right-aligned word with a one-cycle strobe, plus a parity error flag and a framing error flag. Generating the tick is left to the surrounding logic.

Top module: `uart_rx_track`

## Requirements
- R1: After reset, valid_o, data_o, par_err_o and frame_err_o are all zero and the receiver waits for a start edge.
- R2: The serial input passes through two flip-flops. While idle, a high-to-low change seen on a tick starts a frame. If the line is high at the start bit's sample, the receiver drops back to idle and produces no strobe.
- R3: Data bits are taken least-significant first and returned right-aligned, with the unused upper bits of data_o at zero. cfg_nbits_i gives the bit count: 0 is treated as 1 and values above 8 as 8.
- R4: When parity is enabled, one parity bit follows the data. In even mode (cfg_par_odd_i=0) the expected bit is the XOR of the data bits; in odd mode it is the inverse. A mismatch sets par_err_o. With parity disabled there is no parity slot and par_err_o stays 0.
- R5: With stop checking enabled, a low stop bit sets frame_err_o. With it disabled, frame_err_o stays 0 whatever the stop bit is.
- R6: valid_o is a one-cycle pulse, exactly once per accepted frame. data_o, par_err_o and frame_err_o change only together with it.
- R7: Bit timing uses four phases per bit, and the sample is taken at phase 1, the tick after a bit boundary. A line transition seen inside a frame at any phase other than the sample phase restarts the bit at phase 0. It advances the bit only when it comes after the sample. Consecutive samples are therefore 3 to 5 ticks apart.
- R8: Frames of up to eleven slots are received correctly with the sender's bit period up to 2% off nominal in either direction, whatever the data. At 3% off they are received correctly when no run without a transition is longer than six bit slots.
- R9: The configuration is captured on the start edge. Changes to it during a frame have no effect on that frame.
- R10: The receiver is idle again right after the stop-bit sample, so a start edge arriving on the next tick or later is accepted. Back-to-back frames need no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at four times the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| cfg_nbits_i | input | NB_W (4) | Data bit count, 1 to MAX_BITS |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop_chk_i | input | 1 | Check the stop bit |
| valid_o | output | 1 | Received word strobe |
| data_o | output | MAX_BITS (8) | Received word, right-aligned |
| par_err_o | output | 1 | Parity mismatch in the frame just strobed |
| frame_err_o | output | 1 | Low stop bit in the frame just strobed |

## Verification
On every cycle, the assertions check the following:
- the strobe is one cycle wide and only appears with the receiver idle;
- output words keep their upper bits clear and do not change between strobes;
- the error flags stay clear when their checks are off;
- the latched configuration holds for the whole frame;
- consecutive samples stay three to five ticks apart.

Only the bench scenarios can show that the right bits are recovered. They cover every byte value at offset bit rates, each data width and parity mode, wrong parity and low stop bits, short start glitches, configuration changes during a frame, and frames sent with no gap between them.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Ticks per bit period and the phase at which a bit is sampled.
    localparam int OVS     = 4;
    localparam int PH_W    = $clog2(OVS);
    localparam int SAMP_AT = OVS / 2 - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic toggle_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = line_i;
        sync_d.sync = sync_q.meta;
        if (tick_i) begin
            sync_d.prev = sync_q.sync;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        end else begin
            sync_q <= sync_d;
        end
    end

    // Line value as of this tick, compared with the value at the previous tick.
    assign line_o   = sync_q.sync;
    assign toggle_o = tick_i & (sync_q.sync ^ sync_q.prev);
    assign fall_o   = tick_i & sync_q.prev & ~sync_q.sync;

endmodule

// File: rtl/rx_phase_track.sv
module rx_phase_track
    import uart_rx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic start_i,
    input  logic busy_i,
    input  logic toggle_i,
    output logic samp_o,
    output logic adv_o
);

    localparam logic [PH_W-1:0] SAMP_PH = PH_W'(SAMP_AT);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(OVS - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d   = ph_q;
        adv_o  = 1'b0;
        samp_o = 1'b0;
        if (tick_i) begin
            if (start_i) begin
                ph_d.phase = '0;
            end else if (busy_i) begin
                if (toggle_i && (ph_q.phase != SAMP_PH)) begin
                    // Re-centre: this tick becomes the first phase of a bit.
                    // An edge after the sample opens the next bit; an edge
                    // before it means the boundary was already counted.
                    ph_d.phase = '0;
                    adv_o      = (ph_q.phase > SAMP_PH);
                end else begin
                    ph_d.phase = (ph_q.phase == LAST_PH) ? '0 : ph_q.phase + 1'b1;
                    adv_o      = (ph_q.phase == LAST_PH);
                end
                samp_o = (ph_d.phase == SAMP_PH);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Checker state: ticks since the last sample within the current frame.
    logic [3:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_i && start_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_i && busy_i) begin
            if (samp_o) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r7_sample_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (samp_o && seen_q) |-> ((gap_q >= 4'(OVS - 2)) && (gap_q <= 4'(OVS))));

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import uart_rx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                fall_i,
    input  logic                line_i,
    input  logic                samp_i,
    input  logic                adv_i,
    input  logic [NB_W-1:0]     cfg_nbits_i,
    input  logic                cfg_par_en_i,
    input  logic                cfg_par_odd_i,
    input  logic                cfg_stop_chk_i,
    output logic                start_o,
    output logic                busy_o,
    output logic                valid_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                perr_o,
    output logic                ferr_o
);

    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    typedef struct packed {
        rx_state_e           state;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    nlast;
        logic                par_en;
        logic                par_odd;
        logic                stop_chk;
        logic [MAX_BITS-1:0] shreg;
        logic                pacc;
        logic                perr_acc;
        logic                valid;
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
    } fr_t;

    fr_t             fr_d, fr_q;
    logic [NB_W-1:0] n_eff;

    always_comb begin
        if (cfg_nbits_i == '0) begin
            n_eff = NB_W'(1);
        end else if (cfg_nbits_i > NB_W'(MAX_BITS)) begin
            n_eff = NB_W'(MAX_BITS);
        end else begin
            n_eff = cfg_nbits_i;
        end
    end

    always_comb begin
        fr_d       = fr_q;
        fr_d.valid = 1'b0;
        start_o    = 1'b0;
        unique case (fr_q.state)
            ST_IDLE: begin
                if (fall_i) begin
                    start_o       = 1'b1;
                    fr_d.state    = ST_START;
                    fr_d.idx      = '0;
                    fr_d.nlast    = IDX_W'(n_eff - 1'b1);
                    fr_d.par_en   = cfg_par_en_i;
                    fr_d.par_odd  = cfg_par_odd_i;
                    fr_d.stop_chk = cfg_stop_chk_i;
                    fr_d.shreg    = '0;
                    fr_d.pacc     = 1'b0;
                    fr_d.perr_acc = 1'b0;
                end
            end
            ST_START: begin
                if (samp_i && line_i) begin
                    fr_d.state = ST_IDLE;
                end else if (adv_i) begin
                    fr_d.state = ST_DATA;
                    fr_d.idx   = '0;
                end
            end
            ST_DATA: begin
                if (samp_i) begin
                    fr_d.shreg[fr_q.idx] = line_i;
                    fr_d.pacc            = fr_q.pacc ^ line_i;
                end else if (adv_i) begin
                    if (fr_q.idx == fr_q.nlast) begin
                        fr_d.state = fr_q.par_en ? ST_PAR : ST_STOP;
                    end else begin
                        fr_d.idx = fr_q.idx + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (samp_i) begin
                    fr_d.perr_acc = line_i ^ fr_q.pacc ^ fr_q.par_odd;
                end else if (adv_i) begin
                    fr_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (samp_i) begin
                    fr_d.state = ST_IDLE;
                    fr_d.valid = 1'b1;
                    fr_d.data  = fr_q.shreg;
                    fr_d.perr  = fr_q.perr_acc;
                    fr_d.ferr  = fr_q.stop_chk & ~line_i;
                end
            end
            default: fr_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fr_q       <= '0;
            fr_q.state <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign busy_o  = (fr_q.state != ST_IDLE);
    assign valid_o = fr_q.valid;
    assign data_o  = fr_q.data;
    assign perr_o  = fr_q.perr;
    assign ferr_o  = fr_q.ferr;

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fr_q.valid |=> !fr_q.valid);

    a_r6_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fr_q.valid |-> ($stable(fr_q.data) && $stable(fr_q.perr) && $stable(fr_q.ferr)));

    a_r10_idle_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fr_q.valid |-> (fr_q.state == ST_IDLE));

    a_r3_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fr_q.valid |-> (((fr_q.data >> fr_q.nlast) >> 1) == '0));

    a_r4_no_perr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fr_q.valid && !fr_q.par_en) |-> !fr_q.perr);

    a_r5_no_ferr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fr_q.valid && !fr_q.stop_chk) |-> !fr_q.ferr);

    a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (fr_q.state != ST_START)) |->
            ($stable(fr_q.nlast) && $stable(fr_q.par_en) && $stable(fr_q.par_odd)
             && $stable(fr_q.stop_chk)));

endmodule

// File: rtl/uart_rx_track.sv
module uart_rx_track
    import uart_rx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                rx_i,
    input  logic [NB_W-1:0]     cfg_nbits_i,
    input  logic                cfg_par_en_i,
    input  logic                cfg_par_odd_i,
    input  logic                cfg_stop_chk_i,
    output logic                valid_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                par_err_o,
    output logic                frame_err_o
);

    logic line, fall, toggle;
    logic start, busy, samp, adv;

    rx_line_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .line_i  (rx_i),
        .line_o  (line),
        .fall_o  (fall),
        .toggle_o(toggle)
    );

    rx_phase_track u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .start_i (start),
        .busy_i  (busy),
        .toggle_i(toggle),
        .samp_o  (samp),
        .adv_o   (adv)
    );

    rx_frame_ctl #(
        .MAX_BITS(MAX_BITS),
        .NB_W    (NB_W)
    ) u_frame (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fall_i        (fall),
        .line_i        (line),
        .samp_i        (samp),
        .adv_i         (adv),
        .cfg_nbits_i   (cfg_nbits_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .cfg_stop_chk_i(cfg_stop_chk_i),
        .start_o       (start),
        .busy_o        (busy),
        .valid_o       (valid_o),
        .data_o        (data_o),
        .perr_o        (par_err_o),
        .ferr_o        (frame_err_o)
    );

endmodule

// File: tb/uart_rx_track_tb_top.sv
`timescale 1ns/1ps
module uart_rx_track_tb_top;

    localparam int MAXB = 8;
    localparam int NBW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            rx = 1'b1;
    logic [NBW-1:0]  cfg_n = 4'd8;
    logic            cfg_pe = 1'b0;
    logic            cfg_po = 1'b0;
    logic            cfg_sc = 1'b1;
    logic            valid;
    logic [MAXB-1:0] data;
    logic            perr;
    logic            ferr;

    int   checks = 0;
    int   errors = 0;
    int   vtotal = 0;
    int   tcnt = 0;
    bit   done = 1'b0;
    logic [MAXB-1:0] last_data = '0;
    logic last_perr = 1'b0;
    logic last_ferr = 1'b0;

    uart_rx_track #(.MAX_BITS(MAXB), .NB_W(NBW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
        .cfg_nbits_i(cfg_n), .cfg_par_en_i(cfg_pe), .cfg_par_odd_i(cfg_po),
        .cfg_stop_chk_i(cfg_sc), .valid_o(valid), .data_o(data),
        .par_err_o(perr), .frame_err_o(ferr)
    );

    always #2.5 clk = ~clk;

    // Tick every 8 clocks: a nominal bit is 32 clocks.
    always @(negedge clk) begin
        tcnt <= (tcnt + 1) % 8;
        tick <= (tcnt == 7);
    end

    always @(negedge clk) begin
        if (valid) begin
            vtotal    <= vtotal + 1;
            last_data <= data;
            last_perr <= perr;
            last_ferr <= ferr;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per_x100: sender bit period in hundredths of a clock.
    task automatic send_frame(input logic [7:0] d, input int n, input bit pe, input bit po,
                              input bit sc, input bit bad_par, input bit stop_hi,
                              input int per_x100, input int gap, input bit scramble,
                              input string req);
        int   neff;
        int   slots;
        int   base;
        int   t_prev;
        int   t_end;
        logic [7:0] mask;
        logic bits [12];
        neff  = (n < 1) ? 1 : ((n > 8) ? 8 : n);
        mask  = 8'((16'd1 << neff) - 1);
        cfg_n = NBW'(n); cfg_pe = pe; cfg_po = po; cfg_sc = sc;
        @(negedge clk);
        bits[0] = 1'b0;
        for (int i = 0; i < neff; i++) bits[1 + i] = d[i];
        slots = 1 + neff;
        if (pe) begin
            bits[slots] = (^(d & mask)) ^ po ^ bad_par;
            slots++;
        end
        bits[slots] = stop_hi;
        slots++;
        base   = vtotal;
        t_prev = 0;
        for (int s = 0; s < slots; s++) begin
            rx    = bits[s];
            t_end = ((s + 1) * per_x100 + 50) / 100;
            repeat (t_end - t_prev) @(negedge clk);
            t_prev = t_end;
            if (scramble && s == 2) begin
                cfg_n = 4'd3; cfg_pe = ~pe; cfg_po = ~po; cfg_sc = ~sc;
            end
        end
        rx = 1'b1;
        chk("R6", "strobe count", vtotal - base, 1);
        chk(req, "data", int'(last_data), int'(d & mask));
        chk("R4", "parity flag", int'(last_perr), int'(pe & bad_par));
        chk("R5", "framing flag", int'(last_ferr), int'(sc & ~stop_hi));
        cfg_n = NBW'(n); cfg_pe = pe; cfg_po = po; cfg_sc = sc;
        repeat (gap) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int base;
        int per;
        logic [7:0] pat;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", "valid", int'(valid), 0);
        chk("R1", "data", int'(data), 0);
        chk("R1", "perr", int'(perr), 0);
        chk("R1", "ferr", int'(ferr), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1", "no strobe idle", vtotal, 0);

        // R7: every byte, 8 bits, offset rates; gap-free frames exercise R10
        for (int b = 0; b < 256; b++) begin
            per = (b % 3 == 0) ? 3136 : ((b % 3 == 1) ? 3264 : 3200);
            send_frame(8'(b), 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, per,
                       (b % 4 == 0) ? 0 : 12, 1'b0, (b % 4 == 0) ? "R10" : "R7");
        end

        // R3/R4: every width, parity mode and rate
        for (int n = 1; n <= 8; n++) begin
            for (int m = 0; m < 3; m++) begin
                for (int r = 0; r < 3; r++) begin
                    per = (r == 0) ? 3136 : ((r == 1) ? 3200 : 3264);
                    pat = (r == 0) ? 8'h00 : ((r == 1) ? 8'hFF : 8'h5A);
                    send_frame(pat ^ 8'(n * 37), n, m != 0, m == 2, 1'b1, 1'b0, 1'b1,
                               per, 16, 1'b0, "R3");
                end
            end
        end

        // R8: 3% offset with short transition-free runs
        foreach (pat[i]) begin end
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: pat = 8'h55; 1: pat = 8'hAA; 2: pat = 8'h0F;
                3: pat = 8'hF0; 4: pat = 8'h33; default: pat = 8'h81;
            endcase
            send_frame(pat, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3104, 16, 1'b0, "R8");
            send_frame(pat, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3296, 16, 1'b0, "R8");
            send_frame(pat, 8, 1'b1, k[0], 1'b1, 1'b0, 1'b1, 3104, 16, 1'b0, "R8");
            send_frame(pat, 8, 1'b1, k[0], 1'b1, 1'b0, 1'b1, 3296, 16, 1'b0, "R8");
        end

        // R4: wrong parity in both modes
        send_frame(8'hA7, 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3200, 16, 1'b0, "R4");
        send_frame(8'h3C, 7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3200, 16, 1'b0, "R4");
        send_frame(8'h01, 5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3264, 16, 1'b0, "R4");

        // R5: low stop bit with and without checking
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3200, 40, 1'b0, "R5");
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3200, 40, 1'b0, "R5");
        send_frame(8'h2B, 6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3200, 40, 1'b0, "R5");

        // R3: width clamping
        send_frame(8'hFF, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3200, 16, 1'b0, "R3");
        send_frame(8'hC3, 15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3200, 16, 1'b0, "R3");

        // R9: configuration changed mid-frame
        send_frame(8'hE4, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3200, 16, 1'b1, "R9");
        send_frame(8'h1D, 6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3200, 40, 1'b1, "R9");

        // R2: short low glitch is dropped, then a normal frame follows
        cfg_n = 4'd8; cfg_pe = 1'b0; cfg_sc = 1'b1;
        base = vtotal;
        @(negedge clk);
        rx = 1'b0;
        repeat (10) @(negedge clk);
        rx = 1'b1;
        repeat (100) @(negedge clk);
        chk("R2", "glitch strobe count", vtotal - base, 0);
        chk("R2", "glitch leaves data", int'(data), int'(last_data));
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3200, 16, 1'b0, "R2");

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule